// File: doc/BRIEF.md
# Data-Ready Flag and Settling Controller

This block produces the active-low data-ready flag of an oversampling converter's back end. It also decides when the output data register may take a new result word. A free-running counter marks the output periods in place of the real filter. After any restart of the filter, the block blanks the register for a fixed number of whole output periods so that the filter can settle. The restarts are a synchronous reset, a filter-hold (sync) input and a standby input.

Every register update is announced by a fixed-length high window on the flag. The result word is captured at the end of that window, and the flag then falls to show an unread word. A read-complete strobe from the serial side raises the flag again. A word that is still unread when a sync is applied keeps its low flag through the settling time.

A valid indication tells the serial side when the data register may be read safely. It drops during each pre-update window and during standby. Used as a start-convert, a falling edge of `sync_hold` starts a conversion and the next falling edge of `rdy_n` marks its completion.

Top module: `rdy_settle_ctrl`

## Requirements
- R1: While `rst` is high, after the first clock edge, `rdy_n` is 1, `load` is 0, `valid` is 0 and `data` is all zeros.
- R2: If `rst` is first seen low at clock edge k, the first `load` pulse and the first low `rdy_n` appear in the cycle after edge k+SETTLE*PERIOD-1. No `load` occurs before that.
- R3: `load` is high for exactly one cycle. In that cycle `data` holds the `result` value sampled at the edge before it. Without a restart, loads repeat every PERIOD cycles.
- R4: `rdy_n` is high for the PULSE cycles just before every `load` cycle, and `rdy_n` is 0 in the `load` cycle.
- R5: A `rd_done` strobe seen while `rdy_n` is 0 makes `rdy_n` 1 from the next cycle until the next `load`.
- R6: When `rd_done` and an update fall on the same clock edge, the update wins: `load` is 1 and `rdy_n` is 0 in the following cycle.
- R7: While `sync_hold` is high, no update takes place. After release, the next `load` follows the timing of R2, counted from the first edge with `sync_hold` low.
- R8: If `rdy_n` is 0 when `sync_hold` is applied, `rdy_n` stays 0 through the hold and the settling time. It rises only for the PULSE-cycle window before the first new `load`, unless a read raises it earlier.
- R9: If `rdy_n` is 1 during a sync, or a read happens during settling, `rdy_n` stays 1 until the first `load` after settling.
- R10: While `standby` is high, `rdy_n` is 1 from the next cycle, no `load` occurs, and `data` keeps its contents. The first new `load` follows the timing of R2, counted from release.
- R11: A `standby` or `rst` that arrives inside a pre-update window cancels that update, and `rdy_n` stays 1.
- R12: `valid` is 1 once a word has been loaded since reset. It is 0 during every pre-update window and in each cycle after an edge where `standby` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset of all logic |
| sync_hold | input | 1 | Filter hold; release restarts settling (start-convert) |
| standby | input | 1 | Power-down request; data register retained |
| rd_done | input | 1 | Strobe: a data-register read has completed |
| result | input | WORD_W | New result word from the filter stand-in |
| rdy_n | output | 1 | Active-low data-ready flag |
| load | output | 1 | One-cycle strobe: data register just updated |
| data | output | WORD_W | Data register contents |
| valid | output | 1 | Data register stable and safe to read |

## Verification
The read-complete strobe and a register update can land on the same clock edge. The first one drives the flag high and the second drives it low. The bench provokes this by issuing `rd_done` in the last cycle of a pre-update window. It judges the outcome by requiring that `load` is 1 and `rdy_n` is 0 in the next cycle, so the fresh word is not lost. A second overlap puts `standby` or `rst` inside a pre-update window. There the bench requires that no `load` follows and that the flag stays high.

// File: rtl/rdyflag_pkg.sv
package rdyflag_pkg;

    // Control state decoded from the three restart inputs, highest priority last.
    typedef enum logic [1:0] {
        CTL_RUN  = 2'd0,
        CTL_SYNC = 2'd1,
        CTL_STBY = 2'd2,
        CTL_RST  = 2'd3
    } ctl_e;

    // Per-cycle update events produced by the period timer.
    typedef struct packed {
        logic pulse;   // inside the pre-update high window
        logic load;    // last cycle of the window: capture the word
    } upd_s;

    function automatic ctl_e ctl_decode(input logic rst_i, input logic stby_i,
                                        input logic sync_i);
        if (rst_i)       return CTL_RST;
        else if (stby_i) return CTL_STBY;
        else if (sync_i) return CTL_SYNC;
        else             return CTL_RUN;
    endfunction

    // First tick of the window, chosen so the registered flag is high for
    // exactly pulse_len cycles ahead of the load.
    function automatic int unsigned window_start(input int unsigned period,
                                                 input int unsigned pulse_len);
        return period - pulse_len - 1;
    endfunction

endpackage

// File: rtl/rdy_period_timer.sv
module rdy_period_timer
    import rdyflag_pkg::*;
#(
    parameter int unsigned PERIOD = 640,
    parameter int unsigned PULSE  = 500,
    parameter int unsigned SETTLE = 3
) (
    input  logic clk,
    input  ctl_e ctl,
    output upd_s upd
);
    localparam int unsigned TW     = $clog2(PERIOD);
    localparam int unsigned SW     = $clog2(SETTLE + 1);
    localparam int unsigned LAST   = PERIOD - 1;
    localparam int unsigned PSTART = window_start(PERIOD, PULSE);

    logic [TW-1:0] tick_q;
    logic [SW-1:0] settle_q;
    logic          running;
    logic          eligible;

    assign running  = (ctl == CTL_RUN);
    assign eligible = (settle_q >= SW'(SETTLE - 1));

    always_ff @(posedge clk) begin
        if (!running) begin
            tick_q   <= '0;
            settle_q <= '0;
        end else if (tick_q == TW'(LAST)) begin
            tick_q <= '0;
            if (settle_q != SW'(SETTLE))
                settle_q <= settle_q + 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
        end
    end

    always_comb begin
        upd.load  = running && eligible && (tick_q == TW'(LAST));
        upd.pulse = running && eligible && (tick_q >= TW'(PSTART))
                    && (tick_q != TW'(LAST));
    end

endmodule

// File: rtl/rdy_flag_ctrl.sv
module rdy_flag_ctrl
    import rdyflag_pkg::*;
(
    input  logic clk,
    input  ctl_e ctl,
    input  upd_s upd,
    input  logic rd_done,
    output logic rdy_n
);
    // Sync deliberately absent from the force-high list: an unread word
    // keeps its low flag across a filter restart.
    always_ff @(posedge clk) begin
        if (ctl == CTL_RST || ctl == CTL_STBY)
            rdy_n <= 1'b1;
        else if (upd.load)
            rdy_n <= 1'b0;
        else if (upd.pulse || rd_done)
            rdy_n <= 1'b1;
    end

endmodule

// File: rtl/rdy_data_reg.sv
module rdy_data_reg
    import rdyflag_pkg::*;
#(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  ctl_e              ctl,
    input  upd_s              upd,
    input  logic [WORD_W-1:0] result,
    output logic [WORD_W-1:0] data,
    output logic              load,
    output logic              valid
);
    logic has_word_q;
    logic pulse_q;
    logic stby_q;

    always_ff @(posedge clk) begin
        if (ctl == CTL_RST) begin
            data       <= '0;
            has_word_q <= 1'b0;
            load       <= 1'b0;
            pulse_q    <= 1'b0;
            stby_q     <= 1'b0;
        end else begin
            load    <= upd.load;
            pulse_q <= upd.pulse;
            stby_q  <= (ctl == CTL_STBY);
            if (upd.load) begin
                data       <= result;
                has_word_q <= 1'b1;
            end
        end
    end

    assign valid = has_word_q && !pulse_q && !stby_q;

endmodule

// File: rtl/rdy_settle_ctrl.sv
module rdy_settle_ctrl
    import rdyflag_pkg::*;
#(
    parameter int unsigned PERIOD = 640,
    parameter int unsigned PULSE  = 500,
    parameter int unsigned SETTLE = 3,
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_hold,
    input  logic              standby,
    input  logic              rd_done,
    input  logic [WORD_W-1:0] result,
    output logic              rdy_n,
    output logic              load,
    output logic [WORD_W-1:0] data,
    output logic              valid
);
    ctl_e ctl;
    upd_s upd;

    assign ctl = ctl_decode(rst, standby, sync_hold);

    rdy_period_timer #(
        .PERIOD (PERIOD),
        .PULSE  (PULSE),
        .SETTLE (SETTLE)
    ) u_timer (
        .clk (clk),
        .ctl (ctl),
        .upd (upd)
    );

    rdy_flag_ctrl u_flag (
        .clk     (clk),
        .ctl     (ctl),
        .upd     (upd),
        .rd_done (rd_done),
        .rdy_n   (rdy_n)
    );

    rdy_data_reg #(
        .WORD_W (WORD_W)
    ) u_dreg (
        .clk    (clk),
        .ctl    (ctl),
        .upd    (upd),
        .result (result),
        .data   (data),
        .load   (load),
        .valid  (valid)
    );

endmodule

// File: rtl/rdy_settle_chk.sv
module rdy_settle_chk #(
    parameter int unsigned PERIOD = 640,
    parameter int unsigned PULSE  = 500,
    parameter int unsigned SETTLE = 3,
    parameter int unsigned WORD_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_hold,
    input logic              standby,
    input logic              rd_done,
    input logic [WORD_W-1:0] data,
    input logic              rdy_n,
    input logic              load,
    input logic              valid
);
    localparam int unsigned LIM = SETTLE * PERIOD;
    localparam int unsigned RW  = $clog2(LIM + 1);
    localparam int unsigned HW  = $clog2(PULSE + 1);

    logic          hold;
    logic [RW-1:0] rel_q;
    logic [HW-1:0] hi_q;
    logic          rst_seen_q = 1'b0;

    assign hold = rst || standby || sync_hold;

    // Cycles since the last restart was released (saturating).
    always_ff @(posedge clk) begin
        if (hold)
            rel_q <= '0;
        else if (rel_q != RW'(LIM))
            rel_q <= rel_q + 1'b1;
    end

    // Consecutive cycles the flag has been high (saturating).
    always_ff @(posedge clk) begin
        if (!rdy_n)
            hi_q <= '0;
        else if (hi_q != HW'(PULSE))
            hi_q <= hi_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            a_reset_state_r1: assert (rdy_n && !load && !valid && data == '0)
                else $error("reset state violated");
        end
        rst_seen_q <= rst;
    end

    p_settle_window_r7: assert property (@(posedge clk) disable iff (rst)
        load |-> rel_q == RW'(LIM));

    p_single_load_r3: assert property (@(posedge clk) disable iff (rst)
        load |=> !load);

    p_load_flag_low_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> !rdy_n);

    p_window_len_r4: assert property (@(posedge clk) disable iff (rst)
        load |-> hi_q == HW'(PULSE));

    p_read_raises_r5: assert property (@(posedge clk) disable iff (rst)
        rd_done && !rdy_n |=> rdy_n);

    p_standby_flag_r10: assert property (@(posedge clk) disable iff (rst)
        standby |=> rdy_n && !load && $stable(data));

    p_load_valid_r12: assert property (@(posedge clk) disable iff (rst)
        load |-> valid);

endmodule

bind rdy_settle_ctrl rdy_settle_chk #(
    .PERIOD (PERIOD),
    .PULSE  (PULSE),
    .SETTLE (SETTLE),
    .WORD_W (WORD_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sync_hold (sync_hold),
    .standby   (standby),
    .rd_done   (rd_done),
    .data      (data),
    .rdy_n     (rdy_n),
    .load      (load),
    .valid     (valid)
);

// File: tb/rdy_settle_ctrl_tb_top.sv
module rdy_settle_ctrl_tb_top;
    localparam int P  = 640;
    localparam int PU = 500;
    localparam int ST = 3;
    localparam int W  = 24;
    localparam int SP = ST * P;

    // Scenario table: flag low at sync?, read offset (0 = none), expected
    // high run of rdy_n just before the first post-sync load.
    localparam int N_SC = 5;
    localparam bit SC_LOW [N_SC] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1};
    localparam int SC_RD  [N_SC] = '{0, 100, 0, 100, SP - PU + 10};
    localparam int SC_EXP [N_SC] = '{PU, SP - 1 - 100, SP - 1, SP - 1, PU};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sync_hold = 1'b0;
    logic         standby = 1'b0;
    logic         rd_done = 1'b0;
    logic [W-1:0] result = '0;
    logic         rdy_n;
    logic         load;
    logic [W-1:0] data;
    logic         valid;

    int pass_n = 0;
    int fail_n = 0;

    always #10 clk = ~clk;

    rdy_settle_ctrl #(.PERIOD(P), .PULSE(PU), .SETTLE(ST), .WORD_W(W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sync_hold (sync_hold),
        .standby   (standby),
        .rd_done   (rd_done),
        .result    (result),
        .rdy_n     (rdy_n),
        .load      (load),
        .data      (data),
        .valid     (valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        if (ok) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Samples at negedges up to the first load; drives a read strobe at rd_at.
    task automatic run_window(input int maxn, input int rd_at, output int load_at,
                              output int high_run, output int val_low);
        load_at = -1; high_run = 0; val_low = 0;
        for (int i = 1; i <= maxn; i++) begin
            @(negedge clk);
            if (load) begin
                load_at = i;
                break;
            end
            if (rdy_n) high_run++; else high_run = 0;
            if (!valid) val_low++;
            rd_done = (i == rd_at);
        end
        rd_done = 1'b0;
    endtask

    task automatic hold_cycles(input int n, output int loads);
        loads = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (load) loads++;
        end
    endtask

    int la, hr, vl, nl;
    logic [W-1:0] kept;

    initial begin
        repeat (5) @(negedge clk);
        check(rdy_n == 1'b1, "R1", "rdy_n in reset", rdy_n, 1);
        check(load == 1'b0 && valid == 1'b0, "R1", "load/valid in reset", {load, valid}, 0);
        check(data == '0, "R1", "data in reset", data, 0);

        // Reset release
        result = 24'hA5A5A5;
        rst = 1'b0;
        run_window(SP + 10, 0, la, hr, vl);
        check(la == SP, "R2", "first load after reset", la, SP);
        check(hr == SP - 1, "R2", "flag high until first load", hr, SP - 1);
        check(vl == SP - 1, "R12", "valid low before first word", vl, SP - 1);
        check(data == 24'hA5A5A5, "R3", "data at load", data, 24'hA5A5A5);
        check(rdy_n == 1'b0, "R4", "flag low at load", rdy_n, 0);

        // Table of sync scenarios
        for (int s = 0; s < N_SC; s++) begin
            if (!SC_LOW[s]) begin
                rd_done = 1'b1;
                @(negedge clk);
                rd_done = 1'b0;
                check(rdy_n == 1'b1, "R5", "read raises flag", rdy_n, 1);
            end
            sync_hold = 1'b1;
            result = 24'hC00000 + W'(s);
            hold_cycles(20, nl);
            check(rdy_n == !SC_LOW[s], SC_LOW[s] ? "R8" : "R9", "flag kept during sync",
                  rdy_n, !SC_LOW[s]);
            check(nl == 0, "R7", "no load during sync", nl, 0);
            sync_hold = 1'b0;
            run_window(SP + 10, SC_RD[s], la, hr, vl);
            check(la == SP, "R7", "first load after sync", la, SP);
            check(hr == SC_EXP[s], SC_LOW[s] && SC_RD[s] != 100 ? "R8" : "R9",
                  "flag high run before load", hr, SC_EXP[s]);
            check(vl == PU, "R12", "valid low only in window", vl, PU);
            check(data == 24'hC00000 + W'(s), "R3", "data after sync", data,
                  24'hC00000 + s);
            check(rdy_n == 1'b0, "R4", "flag low at load", rdy_n, 0);
        end

        // Steady state period and window length
        result = 24'h123456;
        run_window(P + 5, 0, la, hr, vl);
        check(la == P, "R3", "steady load period", la, P);
        check(hr == PU, "R4", "window length", hr, PU);
        check(data == 24'h123456, "R3", "steady data", data, 24'h123456);

        // Read mid-period
        run_window(P + 5, 10, la, hr, vl);
        check(hr == P - 11, "R5", "flag high from read until load", hr, P - 11);

        // Read strobe on the same edge as the update
        result = 24'h0F0F0F;
        run_window(P + 5, P - 1, la, hr, vl);
        check(la == P, "R6", "load on collision", la, P);
        check(rdy_n == 1'b0, "R6", "flag low after collision", rdy_n, 0);
        check(data == 24'h0F0F0F, "R6", "new word kept", data, 24'h0F0F0F);

        // Standby inside a pre-update window
        kept = data;
        result = 24'h777777;
        repeat (P - 100) @(negedge clk);
        check(rdy_n == 1'b1, "R4", "flag high inside window", rdy_n, 1);
        standby = 1'b1;
        hold_cycles(50, nl);
        check(nl == 0, "R11", "standby cancels update", nl, 0);
        check(rdy_n == 1'b1 && valid == 1'b0, "R10", "flag/valid in standby",
              {rdy_n, valid}, 2);
        check(data == kept, "R10", "data kept in standby", data, kept);
        standby = 1'b0;
        run_window(SP + 10, 0, la, hr, vl);
        check(la == SP, "R10", "first load after standby", la, SP);
        check(hr == SP - 1, "R11", "flag high through settling", hr, SP - 1);
        check(vl == PU, "R12", "valid back after standby", vl, PU);
        check(data == 24'h777777, "R10", "data after standby", data, 24'h777777);

        // Reset inside a pre-update window
        result = 24'h3C3C3C;
        repeat (P - 100) @(negedge clk);
        rst = 1'b1;
        hold_cycles(10, nl);
        check(nl == 0, "R11", "reset cancels update", nl, 0);
        check(rdy_n == 1'b1 && valid == 1'b0 && data == '0, "R1",
              "state after mid-window reset", {rdy_n, valid, (data == '0)}, 5);
        rst = 1'b0;
        run_window(SP + 10, 0, la, hr, vl);
        check(la == SP, "R2", "load after second reset", la, SP);
        check(vl == SP - 1, "R12", "valid low until first word", vl, SP - 1);
        check(data == 24'h3C3C3C, "R3", "data after second reset", data, 24'h3C3C3C);

        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fail_n++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    end

endmodule